// File: doc/BRIEF.md
# Presettable Johnson Divide-by-N Counter

This block is a five-stage twisted-ring (Johnson) counter that divides its clock by any whole ratio from 2 to 10. A 4-bit ratio select sets the ratio. Inside the block, the select chooses which stage outputs are fed back to the first stage, so no external wiring is needed. Both odd and even ratios are available. The first stage output, `q[0]`, is the divided clock.

Two asynchronous controls act on the stages. Both are active high. A reset drives every stage to 1. A preset loads the complement of the 5-bit jam word into the stages. Reset outranks preset, and both outrank the clock. Anti-lock logic watches the active stages. If they hold a pattern outside the selected counting sequence, it pushes 1s into the first stage until the pattern is legal again.

All pins are plain level or edge signals. The block carries no data stream, so it has no valid/ready handshake and no back-pressure.

Top module: `jdiv_counter`

## Requirements
- R1: While `rst` is 1, `q` is 5'b11111 at once, without waiting for a clock edge, whatever `preset_en`, `jam` and the clock do. Reset takes priority over preset.
- R2: When `preset_en` rises while `rst` is 0, each stage is loaded at once with the complement of its jam bit. `jam[i]` goes to `q[i]`, so jam 0 gives 1 and jam 1 gives 0.
- R3: While `preset_en` stays 1 across a rising clock edge, `q` keeps equal to `~jam`, and the clock has no effect.
- R4: With `rst` and `preset_en` low, every rising edge moves `q[i]` into `q[i+1]` for i = 0..3, and `q[0]` takes the feedback bit.
- R5: Between rising clock edges, with no asynchronous control active, `q` holds its value.
- R6: For an even ratio N = 2k (k = 1..5), the feedback bit is `~q[k-1]`. The active window is stages `q[0]..q[k-1]`.
- R7: For an odd ratio N = 2k-1 (k = 2..5), the feedback bit is `~(q[k-2] & q[k-1])`. The active window is again `q[0]..q[k-1]`.
- R8: `ratio_sel` is an unsigned 4-bit ratio. The values 0, 1 and 11..15 act as 10. The ratio in force at a rising edge sets the feedback for that edge, so a change takes effect at the next edge.
- R9: If the active window holds more than one place where adjacent stages differ, the feedback bit is forced to 1. The window is then legal within k-1 edges.
- R10: Once the counter is in the legal sequence, `q[0]` repeats with a period of exactly N clocks and is high for ceil(N/2) of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock; the stages advance on its rising edge |
| rst | input | 1 | Asynchronous reset, active high; drives all stages to 1 |
| preset_en | input | 1 | Asynchronous preset, active high; loads `~jam` into the stages |
| jam | input | 5 | Preset word; bit i is inverted into stage i |
| ratio_sel | input | 4 | Division ratio 2..10; values outside that range act as 10 |
| q | output | 5 | Stage outputs; `q[0]` is the divided clock |

## Verification
The two asynchronous controls take effect within the same clock cycle. The bench pulses reset and preset between edges and checks `q` 1 ns later, before any clock edge arrives. Every clocked result is due one rising edge after the inputs that cause it. The driver sets inputs at the falling edge and pushes the expected stage vector into a queue. The monitor pops that vector 2 ns after the next rising edge, then compares again 4 ns after the edge to confirm the value held. Period and duty are judged over a window of N edges, taken only after 2N edges have passed since a reset.

// File: rtl/jdiv_pkg.sv
package jdiv_pkg;
  localparam int JD_STAGES = 5;
  localparam int JD_SEL_W  = 4;
  localparam int JD_MIN_RATIO = 2;

  // Feedback form chosen by the parity of the ratio
  typedef enum logic {
    FB_EVEN = 1'b0,
    FB_ODD  = 1'b1
  } fb_mode_e;
endpackage

// File: rtl/jdiv_ratio_decode.sv
module jdiv_ratio_decode
  import jdiv_pkg::*;
#(
  parameter int STAGES    = JD_STAGES,
  parameter int SEL_W     = JD_SEL_W,
  parameter int MIN_RATIO = JD_MIN_RATIO
) (
  input  logic [SEL_W-1:0]  ratio_sel,
  output logic [STAGES-1:0] tap_hi,
  output logic [STAGES-1:0] window,
  output fb_mode_e          mode
);
  localparam int MAX_RATIO = 2 * STAGES;

  logic             in_range;
  logic [SEL_W-1:0] ratio;
  logic [SEL_W-1:0] half;

  assign in_range = (ratio_sel >= SEL_W'(MIN_RATIO)) && (ratio_sel <= SEL_W'(MAX_RATIO));
  assign ratio    = in_range ? ratio_sel : SEL_W'(MAX_RATIO);
  assign half     = (ratio + SEL_W'(1)) >> 1;
  assign mode     = ratio[0] ? FB_ODD : FB_EVEN;

  for (genvar i = 0; i < STAGES; i++) begin : g_tap
    assign tap_hi[i] = (half == SEL_W'(i + 1));
    assign window[i] = (half >= SEL_W'(i + 1));
  end

  // R8: every select value maps to exactly one feedback tap
  always_comb begin
    if (!$isunknown(ratio_sel)) begin
      assert_tap_onehot_R8: assert ($countones(tap_hi) == 1)
        else $error("ratio decode produced %b", tap_hi);
    end
  end
endmodule

// File: rtl/jdiv_antilock.sv
module jdiv_antilock
  import jdiv_pkg::*;
#(
  parameter int STAGES = JD_STAGES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              preset_en,
  input  logic [STAGES-1:0] q,
  input  logic [STAGES-1:0] window,
  output logic              illegal
);
  logic [STAGES-2:0] step_seen;

  for (genvar i = 0; i < STAGES - 1; i++) begin : g_step
    assign step_seen[i] = (q[i] ^ q[i+1]) & window[i+1];
  end

  assign illegal = ($countones(step_seen) > 1);

  // R9: edges spent in an illegal window never reach the stage count
  logic [7:0] stuck_cnt;
  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      stuck_cnt <= '0;
    end else if (preset_en || !illegal) begin
      stuck_cnt <= '0;
    end else if (stuck_cnt != 8'hFF) begin
      stuck_cnt <= stuck_cnt + 8'd1;
    end
  end

  assert_recover_R9: assert property (@(posedge clk) disable iff (rst)
    stuck_cnt < 8'(STAGES))
    else $error("anti-lock failed to recover");
endmodule

// File: rtl/jdiv_feedback.sv
module jdiv_feedback
  import jdiv_pkg::*;
#(
  parameter int STAGES = JD_STAGES
) (
  input  logic [STAGES-1:0] q,
  input  logic [STAGES-1:0] tap_hi,
  input  fb_mode_e          mode,
  input  logic              illegal,
  output logic              fb
);
  logic q_top;
  logic q_below;
  logic fb_norm;

  assign q_top   = |(q & tap_hi);
  assign q_below = |(q & (tap_hi >> 1));
  assign fb_norm = (mode == FB_ODD) ? ~(q_below & q_top) : ~q_top;
  assign fb      = illegal | fb_norm;

  // R7: an odd ratio always has a stage below the tap
  always_comb begin
    if (!$isunknown(tap_hi) && !$isunknown(mode) && mode == FB_ODD) begin
      assert_odd_tap_R7: assert (!tap_hi[0])
        else $error("odd ratio with tap on first stage");
    end
  end
endmodule

// File: rtl/jdiv_stages.sv
module jdiv_stages
  import jdiv_pkg::*;
#(
  parameter int STAGES = JD_STAGES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              preset_en,
  input  logic [STAGES-1:0] jam,
  input  logic              fb,
  output logic [STAGES-1:0] q
);
  logic [STAGES-1:0] shifted;
  assign shifted = {q[STAGES-2:0], fb};

  always_ff @(posedge clk or posedge rst or posedge preset_en) begin
    if (rst) begin
      q <= '1;
    end else if (preset_en) begin
      q <= ~jam;
    end else begin
      q <= shifted;
    end
  end

  assert_reset_ones_R1: assert property (@(posedge clk)
    rst |-> (q == '1))
    else $error("reset did not force ones");

  assert_preset_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (preset_en && $past(preset_en) && $stable(jam)) |-> (q == ~jam))
    else $error("preset did not hold inverted jam");
endmodule

// File: rtl/jdiv_counter.sv
module jdiv_counter
  import jdiv_pkg::*;
#(
  parameter int STAGES = JD_STAGES,
  parameter int SEL_W  = JD_SEL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              preset_en,
  input  logic [STAGES-1:0] jam,
  input  logic [SEL_W-1:0]  ratio_sel,
  output logic [STAGES-1:0] q
);
  logic [STAGES-1:0] tap_hi;
  logic [STAGES-1:0] window;
  fb_mode_e          mode;
  logic              illegal;
  logic              fb;

  jdiv_ratio_decode #(.STAGES(STAGES), .SEL_W(SEL_W), .MIN_RATIO(JD_MIN_RATIO)) u_decode (
    .ratio_sel (ratio_sel),
    .tap_hi    (tap_hi),
    .window    (window),
    .mode      (mode)
  );

  jdiv_antilock #(.STAGES(STAGES)) u_antilock (
    .clk       (clk),
    .rst       (rst),
    .preset_en (preset_en),
    .q         (q),
    .window    (window),
    .illegal   (illegal)
  );

  jdiv_feedback #(.STAGES(STAGES)) u_feedback (
    .q       (q),
    .tap_hi  (tap_hi),
    .mode    (mode),
    .illegal (illegal),
    .fb      (fb)
  );

  jdiv_stages #(.STAGES(STAGES)) u_stages (
    .clk       (clk),
    .rst       (rst),
    .preset_en (preset_en),
    .jam       (jam),
    .fb        (fb),
    .q         (q)
  );
endmodule

// File: tb/jdiv_counter_bench.sv
module jdiv_counter_bench;
  logic       clk;
  logic       rst;
  logic       preset_en;
  logic [4:0] jam;
  logic [3:0] ratio_sel;
  logic [4:0] q;

  int n_checks = 0;
  int n_err    = 0;
  string cur_req = "R4";
  logic [4:0] model;
  logic [4:0] exp_q[$];
  logic       hist[$];

  jdiv_counter u_jdiv_counter (
    .clk(clk), .rst(rst), .preset_en(preset_en),
    .jam(jam), .ratio_sel(ratio_sel), .q(q)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input logic ok, input string req, input logic [4:0] act, input logic [4:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // Next state from the requirements (R4, R6, R7, R8, R9)
  function automatic logic [4:0] model_next(input logic [4:0] s, input logic [3:0] sel);
    int n, k, tr;
    logic f;
    n = (sel < 4'd2 || sel > 4'd10) ? 10 : int'(sel);
    k = (n + 1) / 2;
    tr = 0;
    for (int i = 0; i < k - 1; i++) if (s[i] != s[i+1]) tr++;
    if (tr > 1) f = 1'b1;
    else if (n % 2 == 1) f = ~(s[k-2] & s[k-1]);
    else f = ~s[k-1];
    return {s[3:0], f};
  endfunction

  // Monitor: pops one expectation per rising edge, then rechecks the hold
  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      logic [4:0] e;
      e = exp_q.pop_front();
      check(q === e, cur_req, q, e);
      hist.push_back(q[0]);
      #2;
      check(q === e, "R5 hold between edges", q, e);
    end
  end

  task automatic cycle(input logic [3:0] sel, input logic pe, input logic r, input logic [4:0] j);
    logic [4:0] e;
    @(negedge clk);
    ratio_sel = sel; preset_en = pe; rst = r; jam = j;
    if (r) e = 5'b11111;
    else if (pe) e = ~j;
    else e = model_next(model, sel);
    model = e;
    exp_q.push_back(e);
  endtask

  task automatic async_preset(input logic [3:0] sel, input logic [4:0] j, input string req);
    @(negedge clk);
    ratio_sel = sel;
    #1 jam = j; preset_en = 1'b1;
    #1 check(q === ~j, req, q, ~j);
    preset_en = 1'b0;
    model = model_next(~j, sel);
    exp_q.push_back(model);
  endtask

  task automatic period_test(input logic [3:0] sel, input int n, input string req);
    int highs;
    bit per_ok;
    cur_req = req;
    cycle(sel, 1'b0, 1'b1, 5'd0);
    @(posedge clk); #3;
    hist.delete();
    repeat (3 * n) cycle(sel, 1'b0, 1'b0, 5'd0);
    @(posedge clk); #3;
    highs = 0; per_ok = 1'b1;
    if (hist.size() != 3 * n) per_ok = 1'b0;
    else begin
      for (int t = n; t < 2 * n; t++) begin
        if (hist[t] !== hist[t+n]) per_ok = 1'b0;
        highs += int'(hist[t]);
      end
    end
    check(per_ok && highs == (n + 1) / 2, "R10 period/duty", 5'(highs), 5'((n + 1) / 2));
  endtask

  initial begin
    rst = 1'b0; preset_en = 1'b0; jam = 5'd0; ratio_sel = 4'd10; model = 5'b11111;
    #1 rst = 1'b1;
    #2 check(q === 5'b11111, "R1 reset state", q, 5'b11111);
    cur_req = "R1";
    cycle(4'd10, 1'b0, 1'b1, 5'd0);
    cur_req = "R4";
    repeat (12) cycle(4'd10, 1'b0, 1'b0, 5'd0);

    // R6 even ratios and R7 odd ratios, each with an R10 period check
    for (int n = 2; n <= 10; n++)
      period_test(4'(n), n, (n % 2 == 0) ? "R6 even feedback" : "R7 odd feedback");

    // R8 out-of-range selects behave as 10
    period_test(4'd0, 10, "R8 select 0");
    period_test(4'd1, 10, "R8 select 1");
    period_test(4'd11, 10, "R8 select 11");
    period_test(4'd15, 10, "R8 select 15");

    // R8 ratio change mid-run
    cur_req = "R8 ratio change";
    repeat (7) cycle(4'd10, 1'b0, 1'b0, 5'd0);
    repeat (10) cycle(4'd3, 1'b0, 1'b0, 5'd0);
    repeat (10) cycle(4'd8, 1'b0, 1'b0, 5'd0);

    // R2 asynchronous preset with random jam words
    for (int i = 0; i < 20; i++) begin
      logic [3:0] s;
      s = 4'($urandom_range(10, 2));
      async_preset(s, 5'($urandom), "R2 async preset");
      cur_req = "R4 after preset";
      repeat (8) cycle(s, 1'b0, 1'b0, 5'd0);
    end

    // R3 preset held across edges
    cur_req = "R3 preset over clock";
    cycle(4'd6, 1'b1, 1'b0, 5'b10110);
    cycle(4'd6, 1'b1, 1'b0, 5'b10110);
    cycle(4'd6, 1'b1, 1'b0, 5'b10110);
    cur_req = "R4 after held preset";
    repeat (8) cycle(4'd6, 1'b0, 1'b0, 5'd0);

    // R1 reset beats preset, asynchronously and across an edge
    @(negedge clk);
    #1 jam = 5'b10101; preset_en = 1'b1;
    #1 rst = 1'b1;
    #1 check(q === 5'b11111, "R1 reset over preset", q, 5'b11111);
    preset_en = 1'b0;
    #1 rst = 1'b0;
    model = model_next(5'b11111, ratio_sel);
    exp_q.push_back(model);
    cur_req = "R1 reset at edge with preset";
    cycle(4'd7, 1'b1, 1'b1, 5'b00000);
    cur_req = "R4 after reset";
    repeat (8) cycle(4'd7, 1'b0, 1'b0, 5'd0);

    // R9 recovery from every start pattern at every ratio
    for (int s = 0; s < 32; s++) begin
      for (int n = 2; n <= 10; n++) begin
        async_preset(4'(n), ~5'(s), "R2 preset to start state");
        cur_req = "R9 anti-lock recovery";
        repeat (2 * n) cycle(4'(n), 1'b0, 1'b0, 5'd0);
      end
    end

    @(posedge clk); #5;
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin
    #2000000;
    n_checks++; n_err++;
    $display("FAIL watchdog expired (all requirements) actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end
endmodule